// File: doc/BRIEF.md
# Flash Fetch Accelerator Controller

This block sits between a processor read port and a slow flash array. It keeps the most recently fetched flash line for each access class in a holding latch: one latch for instruction fetches and one for data reads. A read that hits a usable latch is answered without touching flash. A miss starts a flash fetch that lasts a run-time programmable number of processor clocks. The flash side is a plain request, line address and line data interface. The controller samples the line data on the clock edge that ends the programmed fetch window.

Two small configuration registers steer the block. The mode register selects between three modes. In the off mode there is no caching. In the partial mode only instruction fetches are cached. In the full mode both classes are cached. The timing register holds the fetch length. Any change of mode empties every latch. The timing register can only be changed while the block is off.

The read port is valid/ready on both the request and the response side. `rd_ready` is high only while no read is in flight. A request is taken on a clock edge where `rd_valid` and `rd_ready` are both high. The response is then held with `rsp_valid` high and `rsp_data` steady until `rsp_ready` is seen high on a clock edge. Only after that can the next request be accepted.

Top module: `flash_fetch_accel`

## Requirements
- R1: After reset the mode register reads 0 (off) and the timing register reads 7. Configuration register select `cfg_addr` = 0 is the mode register (bits 1:0) and `cfg_addr` = 1 is the timing register (bits 2:0).
- R2: Mode codes are 00 off, 01 partial and 10 full. A write of 11 is stored and read back as 00 and behaves as off.
- R3: A mode write whose resulting mode differs from the current one empties both latches, so the next read of each class fetches from flash and returns the current flash contents. Writing the mode already in force leaves the latches intact.
- R4: A miss with timing value N holds `fl_req` high for exactly N cycles with `fl_line_addr` = `rd_addr[15:2]`. `rsp_valid` rises in the cycle after the last request cycle, which is N+1 cycles after acceptance.
- R5: A timing write takes effect only while the mode is off and only if its low three bits are nonzero. Otherwise the write is ignored.
- R6: In the off mode every read goes to flash with the full fetch length, and nothing is retained for later reads.
- R7: In the partial mode an instruction fetch (`rd_is_data` = 0) whose line matches the instruction latch is answered one cycle after acceptance with no flash request. Data reads (`rd_is_data` = 1) always fetch from flash.
- R8: In the full mode any read whose line matches the valid latch of its own class is answered one cycle after acceptance with the latched word (word offset `rd_addr[1:0]`).
- R9: `rd_ready` is low from acceptance until the response has been taken. While `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` is stable.
- R10: Register bits above the defined fields read as zero. Nonzero upper bits in a write do not change how the low field is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 mode, 1 timing |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Contents of the selected register (combinational) |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be accepted |
| rd_addr | input | 16 | Word address of the read |
| rd_is_data | input | 1 | 0 instruction fetch, 1 data read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 32 | Read response word |
| fl_req | output | 1 | Flash fetch in progress |
| fl_line_addr | output | 14 | Flash line address |
| fl_line_data | input | 128 | Flash line contents, sampled at the end of the fetch |

## Verification
The hardest situation to reach is a stale latch. A line must be latched, the flash contents must then change, and a mode change must come between them. Only then does a read show whether the invalidation really forced a fresh fetch. The bench models flash words as carrying a changeable tag value and alters that tag while the block is idle. It then switches mode and checks both the longer latency and the new tag in the returned word. It also rewrites the unchanged mode to confirm that the latched line survives.

// File: rtl/ffa_pkg.sv
package ffa_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_PART = 2'b01,
    MODE_FULL = 2'b10
  } acc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FETCH = 2'b01,
    ST_RESP  = 2'b10
  } fetch_st_e;

  // Whether a given access class may be served from / kept in a latch.
  function automatic logic ffa_allows(acc_mode_e m, logic is_data);
    return (m == MODE_FULL) || ((m == MODE_PART) && !is_data);
  endfunction

endpackage

// File: rtl/ffa_regs.sv
module ffa_regs
  import ffa_pkg::*;
#(
  parameter int CFG_W   = 8,
  parameter int TIM_W   = 3,
  parameter int TIM_RST = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output acc_mode_e        mode,
  output logic [TIM_W-1:0] tim,
  output logic             inval
);

  acc_mode_e        mode_q;
  acc_mode_e        mode_nxt;
  logic [TIM_W-1:0] tim_q;
  logic             tim_wr;
  logic [1:0]       mode_bits;
  logic             unused_hi;

  assign unused_hi = ^wdata[CFG_W-1:TIM_W];

  always_comb begin
    case (wdata[1:0])
      2'b01:   mode_nxt = MODE_PART;
      2'b10:   mode_nxt = MODE_FULL;
      default: mode_nxt = MODE_OFF;   // 00 and the reserved 11
    endcase
  end

  assign inval  = we && !sel && (mode_nxt != mode_q);
  assign tim_wr = we && sel && (mode_q == MODE_OFF) && (wdata[TIM_W-1:0] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      tim_q  <= TIM_W'(TIM_RST);
    end else begin
      if (we && !sel) mode_q <= mode_nxt;
      if (tim_wr)     tim_q  <= wdata[TIM_W-1:0];
    end
  end

  assign mode_bits = mode_q;
  assign rdata = sel ? {{(CFG_W-TIM_W){1'b0}}, tim_q} : {{(CFG_W-2){1'b0}}, mode_bits};
  assign mode  = mode_q;
  assign tim   = tim_q;

endmodule

// File: rtl/ffa_latch.sv
module ffa_latch #(
  parameter int DW  = 32,
  parameter int LW  = 4,
  parameter int TW  = 14,
  parameter int OFS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inval,
  input  logic             fill,
  input  logic [TW-1:0]    fill_tag,
  input  logic [LW*DW-1:0] fill_line,
  input  logic [TW-1:0]    look_tag,
  input  logic [OFS-1:0]   look_off,
  output logic             hit,
  output logic [DW-1:0]    word
);

  logic             valid_q;
  logic [TW-1:0]    tag_q;
  logic [LW*DW-1:0] line_q;

  // Invalidation takes priority over a fill on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n)     valid_q <= 1'b0;
    else if (inval) valid_q <= 1'b0;
    else if (fill)  valid_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q  <= fill_tag;
      line_q <= fill_line;
    end
  end

  assign hit  = valid_q && (tag_q == look_tag);
  assign word = line_q[look_off*DW +: DW];

endmodule

// File: rtl/ffa_fetch_ctl.sv
module ffa_fetch_ctl
  import ffa_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LW    = 4,
  parameter int TW    = 14,
  parameter int OFS   = 2,
  parameter int TIM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [TW-1:0]    rd_tag,
  input  logic [OFS-1:0]   rd_off,
  input  logic             rd_is_data,
  input  logic             hit,
  input  logic [DW-1:0]    hit_word,
  input  logic [TIM_W-1:0] tim,
  input  acc_mode_e        mode,
  input  logic             inval,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  output logic             fl_req,
  output logic [TW-1:0]    fl_line_addr,
  input  logic [LW*DW-1:0] fl_line_data,
  output logic             fill,
  output logic             fill_cls
);

  fetch_st_e        st_q;
  logic [TIM_W-1:0] cnt_q;
  logic [TIM_W-1:0] lat_q;
  logic [TW-1:0]    tag_q;
  logic [OFS-1:0]   off_q;
  logic             cls_q;
  logic [DW-1:0]    data_q;
  logic             fill_ok_q;
  logic             accept;
  logic             last;

  assign accept = (st_q == ST_IDLE) && rd_valid;
  assign last   = (st_q == ST_FETCH) && (cnt_q == lat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (rd_valid) begin
          if (hit) st_q <= ST_RESP;
          else begin
            st_q  <= ST_FETCH;
            cnt_q <= TIM_W'(1);
          end
        end
        ST_FETCH: begin
          if (last) st_q  <= ST_RESP;
          else      cnt_q <= cnt_q + 1'b1;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      tag_q <= rd_tag;
      off_q <= rd_off;
      cls_q <= rd_is_data;
      lat_q <= tim;
      if (hit) data_q <= hit_word;
    end else if (last) begin
      data_q <= fl_line_data[off_q*DW +: DW];
    end
  end

  // A mode change after acceptance forbids the pending fill.
  always_ff @(posedge clk) begin
    if (!rst_n)      fill_ok_q <= 1'b0;
    else if (inval)  fill_ok_q <= 1'b0;
    else if (accept) fill_ok_q <= 1'b1;
  end

  assign rd_ready     = (st_q == ST_IDLE);
  assign rsp_valid    = (st_q == ST_RESP);
  assign rsp_data     = data_q;
  assign fl_req       = (st_q == ST_FETCH);
  assign fl_line_addr = tag_q;
  assign fill         = last && fill_ok_q && ffa_allows(mode, cls_q);
  assign fill_cls     = cls_q;

endmodule

// File: rtl/flash_fetch_accel.sv
module flash_fetch_accel
  import ffa_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 16,
  parameter int LW      = 4,
  parameter int CFG_W   = 8,
  parameter int TIM_W   = 3,
  parameter int TIM_RST = 7,
  localparam int OFS    = $clog2(LW),
  localparam int TW     = AW - OFS,
  localparam int NCLS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_is_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  output logic             fl_req,
  output logic [TW-1:0]    fl_line_addr,
  input  logic [LW*DW-1:0] fl_line_data
);

  acc_mode_e        mode_w;
  logic [TIM_W-1:0] tim_w;
  logic             inval_w;
  logic             fill_w;
  logic             fill_cls_w;
  logic [NCLS-1:0]  lat_hit;
  logic [DW-1:0]    lat_word [NCLS];
  logic             hit_sel;
  logic [TW-1:0]    rd_tag;
  logic [OFS-1:0]   rd_off;

  assign rd_tag = rd_addr[AW-1:OFS];
  assign rd_off = rd_addr[OFS-1:0];

  ffa_regs #(.CFG_W(CFG_W), .TIM_W(TIM_W), .TIM_RST(TIM_RST)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .mode  (mode_w),
    .tim   (tim_w),
    .inval (inval_w)
  );

  for (genvar g = 0; g < NCLS; g++) begin : g_latch
    ffa_latch #(.DW(DW), .LW(LW), .TW(TW), .OFS(OFS)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .inval     (inval_w),
      .fill      (fill_w && (fill_cls_w == g[0])),
      .fill_tag  (fl_line_addr),
      .fill_line (fl_line_data),
      .look_tag  (rd_tag),
      .look_off  (rd_off),
      .hit       (lat_hit[g]),
      .word      (lat_word[g])
    );
  end

  assign hit_sel = ffa_allows(mode_w, rd_is_data) && lat_hit[rd_is_data];

  ffa_fetch_ctl #(.DW(DW), .LW(LW), .TW(TW), .OFS(OFS), .TIM_W(TIM_W)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_tag       (rd_tag),
    .rd_off       (rd_off),
    .rd_is_data   (rd_is_data),
    .hit          (hit_sel),
    .hit_word     (lat_word[rd_is_data]),
    .tim          (tim_w),
    .mode         (mode_w),
    .inval        (inval_w),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .fl_req       (fl_req),
    .fl_line_addr (fl_line_addr),
    .fl_line_data (fl_line_data),
    .fill         (fill_w),
    .fill_cls     (fill_cls_w)
  );

endmodule

// File: rtl/ffa_checker.sv
module ffa_checker #(
  parameter int DW    = 32,
  parameter int CFG_W = 8,
  parameter int TIM_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [DW-1:0]    rsp_data,
  input logic             fl_req,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic [1:0]       cur_mode,
  input logic [TIM_W-1:0] cur_tim
);

  // R4: the end of a flash request window is the response cycle
  a_r4_req_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_req) |-> rsp_valid);

  // R9: a pending response is held steady under back-pressure
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9: no new request is taken while a response is outstanding
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || fl_req) |-> !rd_ready);

  // R10: upper register bits always read zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[CFG_W-1:TIM_W] == '0);

  // R5: timing field frozen while the accelerator is on
  a_r5_tim_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != 2'b00) |=> $stable(cur_tim));

  // R5: fetch length never reaches the reserved zero value
  a_r5_tim_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cur_tim != '0);

  // R2: the reserved mode code is never held
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mode != 2'b11);

  // R6: with the accelerator off an accepted read is never answered next cycle
  a_r6_off_no_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b00 && rd_valid && rd_ready) |=> !rsp_valid);

endmodule

bind flash_fetch_accel ffa_checker #(.DW(DW), .CFG_W(CFG_W), .TIM_W(TIM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .fl_req    (fl_req),
  .cfg_rdata (cfg_rdata),
  .cur_mode  (mode_w),
  .cur_tim   (tim_w)
);

// File: tb/test_flash_fetch_accel.sv
`timescale 1ns/1ps
module test_flash_fetch_accel;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic         cfg_addr = 1'b0;
  logic [7:0]   cfg_wdata = '0;
  logic [7:0]   cfg_rdata;
  logic         rd_valid = 1'b0;
  logic         rd_ready;
  logic [15:0]  rd_addr = '0;
  logic         rd_is_data = 1'b0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [31:0]  rsp_data;
  logic         fl_req;
  logic [13:0]  fl_line_addr;
  logic [127:0] fl_line_data;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  logic [7:0] salt = 8'h11;

  always #5 clk = ~clk;

  flash_fetch_accel i_flash_fetch_accel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_is_data(rd_is_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .fl_req(fl_req), .fl_line_addr(fl_line_addr), .fl_line_data(fl_line_data)
  );

  function automatic logic [31:0] fword(logic [13:0] tag, logic [1:0] off, logic [7:0] s);
    return {s, 6'b0, off, 2'b0, tag};
  endfunction

  always @* begin
    for (int j = 0; j < 4; j++) fl_line_data[j*32 +: 32] = fword(fl_line_addr, 2'(j), salt);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_ph, m_cnt, m_lat, m_mode, m_tim;
  bit [13:0]  m_tag;
  bit [1:0]   m_off;
  bit         m_cls, m_ok;
  bit [31:0]  m_data;
  bit         lv [2];
  bit [13:0]  lt [2];
  bit [7:0]   ls [2];

  function automatic bit may_cache(int md, bit cls);
    return (md == 2) || (md == 1 && !cls);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_mode = 0; m_tim = 7; m_ok = 0;
      lv[0] = 0; lv[1] = 0;
    end else begin
      if (m_ph == 0) begin
        if (rd_valid) begin
          m_tag = rd_addr[15:2]; m_off = rd_addr[1:0]; m_cls = rd_is_data;
          m_lat = m_tim; m_ok = 1;
          if (may_cache(m_mode, m_cls) && lv[m_cls] && lt[m_cls] == m_tag) begin
            m_data = fword(m_tag, m_off, ls[m_cls]); m_ph = 2;
          end else begin
            m_cnt = 1; m_ph = 1;
          end
        end
      end else if (m_ph == 1) begin
        if (m_cnt == m_lat) begin
          m_data = fword(m_tag, m_off, salt);
          if (m_ok && may_cache(m_mode, m_cls)) begin
            lv[m_cls] = 1; lt[m_cls] = m_tag; ls[m_cls] = salt;
          end
          m_ph = 2;
        end else m_cnt++;
      end else if (rsp_ready) m_ph = 0;
      if (cfg_we) begin
        if (!cfg_addr) begin
          int nm;
          nm = (cfg_wdata[1:0] == 2'b11) ? 0 : int'(cfg_wdata[1:0]);
          if (nm != m_mode) begin lv[0] = 0; lv[1] = 0; m_ok = 0; end
          m_mode = nm;
        end else if (m_mode == 0 && cfg_wdata[2:0] != 0) m_tim = int'(cfg_wdata[2:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9", 32'(rd_ready), 32'(m_ph == 0));
      chk("R4", 32'(fl_req), 32'(m_ph == 1));
      chk(cur_req, 32'(rsp_valid), 32'(m_ph == 2));
      if (m_ph == 1) chk("R4", 32'(fl_line_addr), 32'(m_tag));
      if (m_ph == 2) chk(cur_req, rsp_data, m_data);
      chk("R10", 32'(cfg_rdata), cfg_addr ? m_tim : m_mode);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cfg_write(input bit a, input logic [7:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input string req, input bit a, input logic [7:0] exp);
    @(negedge clk); #1;
    cfg_addr = a; #1;
    chk(req, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic do_read(input logic [15:0] a, input bit c, output int lat, output logic [31:0] d);
    @(negedge clk); #1;
    rd_valid = 1'b1; rd_addr = a; rd_is_data = c;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rd_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    d = rsp_data;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input bit c,
                        input int exp_lat, input logic [7:0] exp_salt);
    int lat; logic [31:0] d;
    do_read(a, c, lat, d);
    chk(req, 32'(lat), 32'(exp_lat));
    chk(req, d, fword(a[15:2], a[1:0], exp_salt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cfg_check("R1", 1'b0, 8'h00);
    cfg_check("R1", 1'b1, 8'h07);
    // R6: off mode, every read fetches with full length
    cur_req = "R6";
    rd_chk("R6", 16'h0010, 1'b0, 8, 8'h11);
    rd_chk("R6", 16'h0011, 1'b0, 8, 8'h11);
    // R5 / R10: timing writes
    cfg_write(1'b1, 8'h03); cfg_check("R5", 1'b1, 8'h03);
    cfg_write(1'b1, 8'h00); cfg_check("R5", 1'b1, 8'h03);
    cfg_write(1'b1, 8'hFA); cfg_check("R10", 1'b1, 8'h02);
    // R7: partial mode
    cur_req = "R7";
    cfg_write(1'b0, 8'h01); cfg_check("R2", 1'b0, 8'h01);
    rd_chk("R7", 16'h0040, 1'b0, 3, 8'h11);
    rd_chk("R7", 16'h0041, 1'b0, 1, 8'h11);
    rd_chk("R7", 16'h0080, 1'b1, 3, 8'h11);
    rd_chk("R7", 16'h0080, 1'b1, 3, 8'h11);
    cfg_write(1'b1, 8'h05); cfg_check("R5", 1'b1, 8'h02);
    // R8: full mode (upper write bits ignored); mode change emptied latches
    cur_req = "R8";
    cfg_write(1'b0, 8'hFE); cfg_check("R10", 1'b0, 8'h02);
    rd_chk("R3", 16'h0041, 1'b0, 3, 8'h11);
    rd_chk("R8", 16'h0082, 1'b1, 3, 8'h11);
    rd_chk("R8", 16'h0083, 1'b1, 1, 8'h11);
    rd_chk("R8", 16'h0040, 1'b0, 1, 8'h11);
    // R3: flash content changes, mode change forces fresh fetch
    cur_req = "R3";
    @(negedge clk); #1 salt = 8'h22;
    rd_chk("R8", 16'h0042, 1'b0, 1, 8'h11);
    cfg_write(1'b0, 8'h01);
    rd_chk("R3", 16'h0040, 1'b0, 3, 8'h22);
    cfg_write(1'b0, 8'h01);
    rd_chk("R3", 16'h0043, 1'b0, 1, 8'h22);
    // R2: reserved mode code acts as off
    cur_req = "R2";
    cfg_write(1'b0, 8'h03); cfg_check("R2", 1'b0, 8'h00);
    rd_chk("R2", 16'h0040, 1'b0, 3, 8'h22);
    rd_chk("R2", 16'h0040, 1'b0, 3, 8'h22);
    // R4: several fetch lengths
    cur_req = "R4";
    cfg_write(1'b1, 8'h01);
    rd_chk("R4", 16'h1234, 1'b1, 2, 8'h22);
    cfg_write(1'b1, 8'h07);
    rd_chk("R4", 16'h3FFF, 1'b0, 8, 8'h22);
    cfg_write(1'b1, 8'h04);
    rd_chk("R4", 16'h0005, 1'b1, 5, 8'h22);
    // R9: back-pressure on the response
    cur_req = "R9";
    cfg_write(1'b0, 8'h02);
    @(negedge clk); #1 rsp_ready = 1'b0;
    begin
      int lat; logic [31:0] d;
      do_read(16'h0200, 1'b1, lat, d);
      chk("R9", 32'(lat), 32'd5);
      @(negedge clk); #1 rd_valid = 1'b1; rd_addr = 16'h0300;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk("R9", 32'(rsp_valid), 32'd1);
        chk("R9", rsp_data, d);
        chk("R9", 32'(rd_ready), 32'd0);
      end
      rd_valid = 1'b0;
      #1 rsp_ready = 1'b1;
      @(negedge clk);
      chk("R9", 32'(rsp_valid), 32'd0);
      chk("R9", 32'(rd_ready), 32'd1);
    end
    rd_chk("R8", 16'h0201, 1'b1, 1, 8'h22);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule